// File: doc/BRIEF.md
# Dual-Direction Audio Sample FIFO with Threshold DMA Requests

This block sits between a host port (register writes or a DMA engine) and a serial audio engine. It holds two small sample queues, one for each direction. The transmit queue takes 16-bit samples from the host and hands them to the serial engine. The receive queue takes samples from the serial engine and hands them to the host. Each queue reports its fill count and four level flags. Each queue also raises a DMA request when its fill count crosses a programmable threshold. Transmit asks for more data when it runs low. Receive asks to be drained when it runs high.

Host words are one bit wider than a sample. Bit 16 of a transmit write marks the word as valid. Bit 16 of a receive read tells the host that the low 16 bits hold real data. The block also watches for queue events: level conditions, reads or pops on an empty queue (starvation), writes or pushes into a full queue (overflow), and completed word transfers on the engine side. These events are kept in a sticky status word. A per-bit mask and a global enable combine that word into one interrupt line, and a clear strobe resets the status word.

Top module: `afifo_pair`

## Requirements
- R1: A transmit write (`txWrEn`) is stored only when bit 16 of `txWrWord` is 1, the transmit FIFO is enabled and the FIFO is not full. A write with bit 16 at 0 changes neither the count nor the contents.
- R2: Both queues are first-in first-out. `txData` always shows the oldest transmit sample, and `txPop` removes it. `rxRdWord` is `{1'b1, oldest sample}` when the receive queue holds data and all zeros when it is empty. `rxRdEn` removes the oldest sample. A push and a read in the same cycle leave the count unchanged.
- R3: Each flag vector is `{almostFull, full, almostEmpty, empty}` in bits 3..0. The flags mean: empty when count is 0, almostEmpty when count ≤ MARGIN, full when count = DEPTH, and almostFull when count ≥ DEPTH − MARGIN.
- R4: `txDmaReq` is high exactly when `txDmaEn`, `txFifoEn` and `txCount ≤ txLevel` all hold.
- R5: `rxDmaReq` is high exactly when `rxDmaEn`, `rxFifoEn` and `rxCount ≥ rxLevel` all hold.
- R6: A valid transmit write or a receive push into a full, enabled queue is dropped. The count and the oldest sample stay the same, and the direction's overflow status bit is set.
- R7: A transmit pop or a receive read on an empty, enabled queue changes nothing in the queue and sets the direction's starvation status bit.
- R8: While a direction's FIFO enable is low, its queue is emptied at the next edge and held empty. All writes, pushes, pops and reads on it are ignored, and it records no status events.
- R9: Status bits are numbered as follows. Bit 0 is word transfer. Transmit uses bits 1 to 6: empty, almostEmpty, full, almostFull, starvation and overflow. Receive uses bits 7 to 12 in the same order. A bit is set at the clock edge where its condition is seen, and it stays set until `clrStatus`. A clear empties the word at the next edge, but an event present in that same cycle is still recorded.
- R10: `irqPending` equals `irqGlobalEn` AND the OR of (`statusWord` AND `intMask`).
- R11: The word-transfer bit is set by an accepted transmit pop or an accepted receive push.
- R12: After reset both counts are 0, `statusWord` is 0, `irqPending`, `txDmaReq` and `rxDmaReq` are 0, and `rxRdWord` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txFifoEn | input | 1 | Transmit queue enable; low flushes it |
| rxFifoEn | input | 1 | Receive queue enable; low flushes it |
| txDmaEn | input | 1 | Allows transmit DMA requests |
| rxDmaEn | input | 1 | Allows receive DMA requests |
| txLevel | input | CNT_W | Transmit threshold for the DMA request |
| rxLevel | input | CNT_W | Receive threshold for the DMA request |
| txWrEn | input | 1 | Host write strobe for the transmit queue |
| txWrWord | input | DATA_W+1 | Host write word; bit 16 = valid |
| txPop | input | 1 | Serial engine takes one transmit sample |
| txData | output | DATA_W | Oldest transmit sample |
| rxPush | input | 1 | Serial engine delivers one receive sample |
| rxPushData | input | DATA_W | Sample delivered by the serial engine |
| rxRdEn | input | 1 | Host read strobe for the receive queue |
| rxRdWord | output | DATA_W+1 | `{valid, sample}` of the oldest receive entry |
| txCount | output | CNT_W | Transmit fill count |
| rxCount | output | CNT_W | Receive fill count |
| txFlags | output | 4 | Transmit `{almostFull, full, almostEmpty, empty}` |
| rxFlags | output | 4 | Receive `{almostFull, full, almostEmpty, empty}` |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |
| intMask | input | 13 | Per-bit interrupt enables for `statusWord` |
| irqGlobalEn | input | 1 | Global interrupt enable |
| clrStatus | input | 1 | Clears all sticky status bits |
| statusWord | output | 13 | Sticky event bits (layout in R9) |
| irqPending | output | 1 | Combined interrupt |

## Verification
The bench builds the block with DEPTH 8 and MARGIN 2, which gives a 4-bit count. With these values, eight writes fill a queue, so the full flag, the overflow drop and both almost flags are all reached within a short vector table. A threshold of 3 puts the DMA request edge in the middle of a fill, so the bench sees it rise and fall on both the filling and the draining passes. Starvation, simultaneous push and read, flushing through the enable, and the interplay of clear with events that are still present are then driven as directed cases.

// File: rtl/afifo_pkg.sv
`timescale 1ns/1ps
package afifo_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoStrb_t;

  typedef struct packed {
    logic almostFull;
    logic full;
    logic almostEmpty;
    logic empty;
  } fifoFlags_t;

  localparam int EV_W       = 13;
  localparam int EV_XFER    = 0;
  localparam int EV_TX_BASE = 1;
  localparam int EV_RX_BASE = 7;
  localparam int OFS_EMPTY  = 0;
  localparam int OFS_AEMPTY = 1;
  localparam int OFS_FULL   = 2;
  localparam int OFS_AFULL  = 3;
  localparam int OFS_STARVE = 4;
  localparam int OFS_OVF    = 5;
  localparam int DIR_TX     = 0;
  localparam int DIR_RX     = 1;
endpackage

// File: rtl/sample_fifo.sv
`timescale 1ns/1ps
module sample_fifo
  import afifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int MARGIN = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  fifoStrb_t                        strb,
  input  logic [DATA_W-1:0]                wrData,
  output logic [DATA_W-1:0]                headData,
  output logic [$clog2(DEPTH+1)-1:0]       count,
  output fifoFlags_t                       flags
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] AE_CNT    = CNT_W'(MARGIN);
  localparam logic [CNT_W-1:0] AF_CNT    = CNT_W'(DEPTH - MARGIN);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strb.push && !strb.flush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData          = mem[rdPtr];
  assign flags.empty       = (count == '0);
  assign flags.almostEmpty = (count <= AE_CNT);
  assign flags.full        = (count == FULL_CNT);
  assign flags.almostFull  = (count >= AF_CNT);

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);
  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> count == '0);
  // R6
  push_guarded_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && !strb.pop && !strb.flush) |=> count == $past(count) + 1'b1);
  // R7
  pop_guarded_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !strb.push && !strb.flush) |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/afifo_datapath.sv
`timescale 1ns/1ps
module afifo_datapath
  import afifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int MARGIN = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  fifoStrb_t                   strb     [2],
  input  logic [DATA_W-1:0]           wrData   [2],
  output logic [DATA_W-1:0]           headData [2],
  output logic [$clog2(DEPTH+1)-1:0]  count    [2],
  output fifoFlags_t                  flags    [2]
);
  for (genvar d = 0; d < 2; d++) begin : g_dir
    sample_fifo #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .MARGIN (MARGIN)
    ) u_fifo (
      .clk      (clk),
      .rstN     (rstN),
      .strb     (strb[d]),
      .wrData   (wrData[d]),
      .headData (headData[d]),
      .count    (count[d]),
      .flags    (flags[d])
    );
  end
endmodule

// File: rtl/afifo_control.sv
`timescale 1ns/1ps
module afifo_control
  import afifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txFifoEn,
  input  logic               rxFifoEn,
  input  logic               txDmaEn,
  input  logic               rxDmaEn,
  input  logic [CNT_W-1:0]   txLevel,
  input  logic [CNT_W-1:0]   rxLevel,
  input  logic               txWrEn,
  input  logic               txWrValid,
  input  logic               txPop,
  input  logic               rxPush,
  input  logic               rxRdEn,
  input  logic [CNT_W-1:0]   count    [2],
  input  fifoFlags_t         flags    [2],
  input  logic [DATA_W-1:0]  rxHead,
  input  logic [EV_W-1:0]    intMask,
  input  logic               irqGlobalEn,
  input  logic               clrStatus,
  output fifoStrb_t          strb     [2],
  output logic [DATA_W:0]    rxRdWord,
  output logic               txDmaReq,
  output logic               rxDmaReq,
  output logic [EV_W-1:0]    statusWord,
  output logic               irqPending
);
  logic txWrTry, txWrOk, txWrOvf, txPopOk, txStarve;
  logic rxPushOk, rxPushOvf, rxRdOk, rxStarve;
  logic [EV_W-1:0] setVec;
  logic [1:0] dirEn;
  logic [1:0] ovfEv, starveEv;

  assign txWrTry   = txFifoEn && txWrEn && txWrValid;
  assign txWrOk    = txWrTry && !flags[DIR_TX].full;
  assign txWrOvf   = txWrTry && flags[DIR_TX].full;
  assign txPopOk   = txFifoEn && txPop && !flags[DIR_TX].empty;
  assign txStarve  = txFifoEn && txPop && flags[DIR_TX].empty;
  assign rxPushOk  = rxFifoEn && rxPush && !flags[DIR_RX].full;
  assign rxPushOvf = rxFifoEn && rxPush && flags[DIR_RX].full;
  assign rxRdOk    = rxFifoEn && rxRdEn && !flags[DIR_RX].empty;
  assign rxStarve  = rxFifoEn && rxRdEn && flags[DIR_RX].empty;

  always_comb begin
    strb[DIR_TX] = '{push: txWrOk,   pop: txPopOk, flush: !txFifoEn};
    strb[DIR_RX] = '{push: rxPushOk, pop: rxRdOk,  flush: !rxFifoEn};
  end

  assign dirEn    = {rxFifoEn, txFifoEn};
  assign ovfEv    = {rxPushOvf, txWrOvf};
  assign starveEv = {rxStarve, txStarve};

  always_comb begin
    setVec = '0;
    setVec[EV_XFER] = txPopOk || rxPushOk;
    for (int d = 0; d < 2; d++) begin
      setVec[(d == 0 ? EV_TX_BASE : EV_RX_BASE) + OFS_EMPTY]  = dirEn[d] && flags[d].empty;
      setVec[(d == 0 ? EV_TX_BASE : EV_RX_BASE) + OFS_AEMPTY] = dirEn[d] && flags[d].almostEmpty;
      setVec[(d == 0 ? EV_TX_BASE : EV_RX_BASE) + OFS_FULL]   = dirEn[d] && flags[d].full;
      setVec[(d == 0 ? EV_TX_BASE : EV_RX_BASE) + OFS_AFULL]  = dirEn[d] && flags[d].almostFull;
      setVec[(d == 0 ? EV_TX_BASE : EV_RX_BASE) + OFS_STARVE] = starveEv[d];
      setVec[(d == 0 ? EV_TX_BASE : EV_RX_BASE) + OFS_OVF]    = ovfEv[d];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusWord <= '0;
    else       statusWord <= (clrStatus ? '0 : statusWord) | setVec;
  end

  assign irqPending = irqGlobalEn && |(statusWord & intMask);
  assign txDmaReq   = txDmaEn && txFifoEn && (count[DIR_TX] <= txLevel);
  assign rxDmaReq   = rxDmaEn && rxFifoEn && (count[DIR_RX] >= rxLevel);
  assign rxRdWord   = (rxFifoEn && !flags[DIR_RX].empty) ? {1'b1, rxHead} : '0;

  // R6
  tx_ovf_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txFifoEn && txWrEn && txWrValid && flags[DIR_TX].full)
      |=> statusWord[EV_TX_BASE + OFS_OVF]);
  // R7
  rx_starve_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxFifoEn && rxRdEn && flags[DIR_RX].empty)
      |=> statusWord[EV_RX_BASE + OFS_STARVE]);
  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrStatus |=> ((statusWord & $past(statusWord)) == $past(statusWord)));
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPending |-> irqGlobalEn);
  // R4
  tx_req_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDmaReq |-> (txDmaEn && txFifoEn));
  // R8
  rx_disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxFifoEn |-> !rxDmaReq && rxRdWord == '0);
endmodule

// File: rtl/afifo_pair.sv
`timescale 1ns/1ps
module afifo_pair
  import afifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int MARGIN = 4,
  localparam int CNT_W  = $clog2(DEPTH+1),
  localparam int WORD_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txFifoEn,
  input  logic              rxFifoEn,
  input  logic              txDmaEn,
  input  logic              rxDmaEn,
  input  logic [CNT_W-1:0]  txLevel,
  input  logic [CNT_W-1:0]  rxLevel,
  input  logic              txWrEn,
  input  logic [WORD_W-1:0] txWrWord,
  input  logic              txPop,
  output logic [DATA_W-1:0] txData,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxPushData,
  input  logic              rxRdEn,
  output logic [WORD_W-1:0] rxRdWord,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount,
  output logic [3:0]        txFlags,
  output logic [3:0]        rxFlags,
  output logic              txDmaReq,
  output logic              rxDmaReq,
  input  logic [EV_W-1:0]   intMask,
  input  logic              irqGlobalEn,
  input  logic              clrStatus,
  output logic [EV_W-1:0]   statusWord,
  output logic              irqPending
);
  fifoStrb_t         strb     [2];
  logic [DATA_W-1:0] wrData   [2];
  logic [DATA_W-1:0] headData [2];
  logic [CNT_W-1:0]  count    [2];
  fifoFlags_t        flags    [2];

  assign wrData[DIR_TX] = txWrWord[DATA_W-1:0];
  assign wrData[DIR_RX] = rxPushData;

  afifo_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MARGIN(MARGIN)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .headData(headData), .count(count), .flags(flags)
  );

  afifo_control #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN),
    .txFifoEn(txFifoEn), .rxFifoEn(rxFifoEn),
    .txDmaEn(txDmaEn), .rxDmaEn(rxDmaEn),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .txWrEn(txWrEn), .txWrValid(txWrWord[DATA_W]),
    .txPop(txPop), .rxPush(rxPush), .rxRdEn(rxRdEn),
    .count(count), .flags(flags), .rxHead(headData[DIR_RX]),
    .intMask(intMask), .irqGlobalEn(irqGlobalEn), .clrStatus(clrStatus),
    .strb(strb), .rxRdWord(rxRdWord),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq),
    .statusWord(statusWord), .irqPending(irqPending)
  );

  assign txData  = headData[DIR_TX];
  assign txCount = count[DIR_TX];
  assign rxCount = count[DIR_RX];
  assign txFlags = flags[DIR_TX];
  assign rxFlags = flags[DIR_RX];
endmodule

// File: tb/tb_afifo_pair.sv
`timescale 1ns/1ps
module tb_afifo_pair;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int MARGIN = 2;
  localparam int CNT_W  = $clog2(DEPTH+1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txFifoEn = 0, rxFifoEn = 0, txDmaEn = 0, rxDmaEn = 0;
  logic [CNT_W-1:0] txLevel = '0, rxLevel = '0;
  logic txWrEn = 0, txPop = 0, rxPush = 0, rxRdEn = 0;
  logic [DATA_W:0] txWrWord = '0;
  logic [DATA_W-1:0] rxPushData = '0;
  logic [12:0] intMask = '0;
  logic irqGlobalEn = 0, clrStatus = 0;
  logic [DATA_W-1:0] txData;
  logic [DATA_W:0] rxRdWord;
  logic [CNT_W-1:0] txCount, rxCount;
  logic [3:0] txFlags, rxFlags;
  logic txDmaReq, rxDmaReq, irqPending;
  logic [12:0] statusWord;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  afifo_pair #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MARGIN(MARGIN)) dut (
    .clk(clk), .rstN(rstN),
    .txFifoEn(txFifoEn), .rxFifoEn(rxFifoEn), .txDmaEn(txDmaEn), .rxDmaEn(rxDmaEn),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .txWrEn(txWrEn), .txWrWord(txWrWord), .txPop(txPop), .txData(txData),
    .rxPush(rxPush), .rxPushData(rxPushData), .rxRdEn(rxRdEn), .rxRdWord(rxRdWord),
    .txCount(txCount), .rxCount(rxCount), .txFlags(txFlags), .rxFlags(rxFlags),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq),
    .intMask(intMask), .irqGlobalEn(irqGlobalEn), .clrStatus(clrStatus),
    .statusWord(statusWord), .irqPending(irqPending)
  );

  // op: 0 idle, 1 valid write, 2 write with bit 16 low, 3 engine pop
  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] data;
    logic [3:0]  cnt;
    logic        req;
    logic [3:0]  flg;
    logic [15:0] head;
  } vecT;

  localparam int NV = 19;
  localparam vecT VECS [NV] = '{
    '{2'd1, 16'h1100, 4'd1, 1'b1, 4'b0010, 16'h1100},
    '{2'd2, 16'hDEAD, 4'd1, 1'b1, 4'b0010, 16'h1100},
    '{2'd1, 16'h1101, 4'd2, 1'b1, 4'b0010, 16'h1100},
    '{2'd1, 16'h1102, 4'd3, 1'b1, 4'b0000, 16'h1100},
    '{2'd1, 16'h1103, 4'd4, 1'b0, 4'b0000, 16'h1100},
    '{2'd1, 16'h1104, 4'd5, 1'b0, 4'b0000, 16'h1100},
    '{2'd1, 16'h1105, 4'd6, 1'b0, 4'b1000, 16'h1100},
    '{2'd1, 16'h1106, 4'd7, 1'b0, 4'b1000, 16'h1100},
    '{2'd1, 16'h1107, 4'd8, 1'b0, 4'b1100, 16'h1100},
    '{2'd1, 16'hBEEF, 4'd8, 1'b0, 4'b1100, 16'h1100},
    '{2'd3, 16'h0000, 4'd7, 1'b0, 4'b1000, 16'h1101},
    '{2'd3, 16'h0000, 4'd6, 1'b0, 4'b1000, 16'h1102},
    '{2'd3, 16'h0000, 4'd5, 1'b0, 4'b0000, 16'h1103},
    '{2'd3, 16'h0000, 4'd4, 1'b0, 4'b0000, 16'h1104},
    '{2'd3, 16'h0000, 4'd3, 1'b1, 4'b0000, 16'h1105},
    '{2'd3, 16'h0000, 4'd2, 1'b1, 4'b0010, 16'h1106},
    '{2'd3, 16'h0000, 4'd1, 1'b1, 4'b0010, 16'h1107},
    '{2'd3, 16'h0000, 4'd0, 1'b1, 4'b0011, 16'h0000},
    '{2'd3, 16'h0000, 4'd0, 1'b1, 4'b0011, 16'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idleOps();
    txWrEn = 0; txPop = 0; rxPush = 0; rxRdEn = 0; clrStatus = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R12 reset state
    check("R12 txCount", 32'(txCount), 0);
    check("R12 rxCount", 32'(rxCount), 0);
    check("R12 status", 32'(statusWord), 0);
    check("R12 irq", 32'(irqPending), 0);
    check("R12 rxRdWord", 32'(rxRdWord), 0);
    txDmaEn = 1; rxDmaEn = 1;
    tick();
    check("R4 no req while fifo disabled", 32'(txDmaReq), 0);
    check("R5 no req while fifo disabled", 32'(rxDmaReq), 0);
    rxDmaEn = 0;

    txFifoEn = 1; txLevel = CNT_W'(3);
    tick();
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        2'd1: begin txWrEn = 1; txWrWord = {1'b1, VECS[i].data}; end
        2'd2: begin txWrEn = 1; txWrWord = {1'b0, VECS[i].data}; end
        2'd3: txPop = 1;
        default: ;
      endcase
      tick();
      idleOps();
      check($sformatf("R1/R6/R7 count row %0d", i), 32'(txCount), 32'(VECS[i].cnt));
      check($sformatf("R4 txDmaReq row %0d", i), 32'(txDmaReq), 32'(VECS[i].req));
      check($sformatf("R3 txFlags row %0d", i), 32'(txFlags), 32'(VECS[i].flg));
      if (VECS[i].cnt != 0)
        check($sformatf("R2 txData row %0d", i), 32'(txData), 32'(VECS[i].head));
    end
    // R6 R7 R11 R9: all transmit events and word transfer recorded
    check("R9 status after tx pass", 32'(statusWord), 32'h007F);

    clrStatus = 1;
    tick();
    idleOps();
    check("R9 clear keeps present empty events", 32'(statusWord), 32'h0006);
    tick();
    check("R9 sticky after clear", 32'(statusWord), 32'h0006);

    intMask = 13'h040; irqGlobalEn = 1;
    #1 check("R10 masked bit gives no irq", 32'(irqPending), 0);
    intMask = 13'h002; irqGlobalEn = 0;
    #1 check("R10 global enable low", 32'(irqPending), 0);
    irqGlobalEn = 1;
    #1 check("R10 irq raised", 32'(irqPending), 1);
    tick();

    rxFifoEn = 1; rxDmaEn = 1; rxLevel = CNT_W'(3);
    tick();
    rxPush = 1; rxPushData = 16'hA000;
    tick(); idleOps();
    check("R11 xfer set by rx push", 32'(statusWord[0]), 1);
    rxPush = 1; rxPushData = 16'hA001;
    tick(); idleOps();
    check("R5 rx count 2", 32'(rxCount), 2);
    check("R5 no req below level", 32'(rxDmaReq), 0);
    rxPush = 1; rxPushData = 16'hA002;
    tick(); idleOps();
    check("R5 req at level", 32'(rxDmaReq), 1);
    check("R2 rx head word", 32'(rxRdWord), 32'h1A000);
    rxRdEn = 1;
    tick(); idleOps();
    check("R2 read pops", 32'(rxRdWord), 32'h1A001);
    check("R5 req drops", 32'(rxDmaReq), 0);
    rxRdEn = 1; tick(); rxRdEn = 1; tick(); idleOps();
    check("R2 empty reads zero", 32'(rxRdWord), 0);
    rxRdEn = 1;
    tick(); idleOps();
    check("R7 rx count unchanged", 32'(rxCount), 0);
    check("R7 rx starvation", 32'(statusWord[11]), 1);
    rxPush = 1; rxPushData = 16'hB000;
    tick(); idleOps();
    rxPush = 1; rxPushData = 16'hB001; rxRdEn = 1;
    tick(); idleOps();
    check("R2 push and read count", 32'(rxCount), 1);
    check("R2 push and read head", 32'(rxRdWord), 32'h1B001);
    for (int k = 0; k < 7; k++) begin
      rxPush = 1; rxPushData = 16'hC000 + 16'(k);
      tick();
    end
    idleOps();
    check("R3 rx full flags", 32'(rxFlags), 32'hC);
    rxPush = 1; rxPushData = 16'hDEAD;
    tick(); idleOps();
    check("R6 rx count kept", 32'(rxCount), 8);
    check("R6 rx head kept", 32'(rxRdWord), 32'h1B001);
    check("R6 rx overflow", 32'(statusWord[12]), 1);

    rxFifoEn = 0;
    tick();
    check("R8 rx flushed", 32'(rxCount), 0);
    check("R8 rx word zero", 32'(rxRdWord), 0);
    check("R8 rx req low", 32'(rxDmaReq), 0);
    rxPush = 1; rxPushData = 16'h5555;
    tick(); idleOps();
    check("R8 push ignored", 32'(rxCount), 0);
    clrStatus = 1;
    tick(); idleOps();
    check("R8 no rx events while disabled", 32'(statusWord), 32'h0006);

    txFifoEn = 0; clrStatus = 1;
    tick(); idleOps();
    check("R8 no tx events while disabled", 32'(statusWord), 0);
    check("R10 irq clears", 32'(irqPending), 0);
    txWrEn = 1; txWrWord = {1'b1, 16'h7777};
    tick(); idleOps();
    check("R8 tx write ignored", 32'(txCount), 0);

    summary();
    $finish;
  end
endmodule